// File: doc/BRIEF.md
# RAM-backed FIFO controller with boundary interrupt

This block turns a region of on-chip byte RAM into circular FIFO storage between a CPU and a byte-wide peripheral. It has two independent channels that can run at the same time. The receive channel takes bytes from the peripheral and writes them into RAM. The CPU reads those bytes straight from RAM, using the channel's read start address and its valid byte count, and then releases them. The transmit channel works the other way round. The CPU fills RAM, commits a byte count, and the peripheral then pops bytes out of RAM in order.

Each channel has a window size chosen by a 3-bit code and a base address aligned to that size. It keeps a head pointer and a valid count. From these it derives the tail pointer and the free count, and valid plus free always equals the window size. Two errors are held as sticky flags. Over-read means a consumer asked for more than was valid. Over-write means a producer offered more than was free. A third sticky flag records the peripheral-side pointer wrapping past the end of the window. Together with a per-channel enable, this flag drives a single interrupt line, so the CPU can learn that a fixed-size block has finished even when the peripheral cannot signal it.

The CPU reaches the block through a small register port and through a separate byte port into the RAM. Both channels share one peripheral-side RAM port, and the receive channel wins when both channels request it in the same cycle.

Top module: `ram_fifo_ctl`

## Requirements
- R1: After reset, both channels report valid count 0, free count 16 (size code 0), status 0, size code 0 and interrupt enable 0, and `irq` is low.
- R2: Writing the config register (word 0 of a channel: bits [2:0] size code, bit 3 interrupt enable) selects a window of 2^(min(code, AW-4)+4) bytes and empties the channel: head offset 0, valid 0, free equal to the size. Valid plus free never exceeds the size.
- R3: A receive push that is accepted writes `rx_byte` to the RAM at the aligned base OR the tail offset. The valid count rises by one and the tail offset advances modulo the size, both visible in the next cycle.
- R4: A transmit commit (CPU write of n to word 3 of channel 1) adds n to the valid count. An accepted `tx_pop` returns the byte at the head address on `tx_byte`, with `tx_byte_vld` high in the cycle after the pop. The head then advances by one modulo the size.
- R5: A receive release (CPU write of n to word 3 of channel 0) with n not above the valid count advances the head by n modulo the size and lowers the valid count by n.
- R6: The over-write flag (status bit 1) is set in two cases. One is a receive push with free count 0, which writes nothing and leaves the count unchanged. The other is a transmit commit of n larger than the free count, which leaves the count unchanged.
- R7: The over-read flag (status bit 0) is set in two cases. One is a transmit pop with valid count 0, which returns no byte. The other is a receive release of n larger than the valid count, which leaves the head and count unchanged.
- R8: While either error flag of a channel is set, its peripheral-side transfers are ignored. CPU commits and releases still work. Flags are cleared only by writing 1 to the bit in the status register (word 5).
- R9: The boundary flag (status bit 2) is set when the peripheral-side pointer of a channel moves from offset size-1 to 0. That pointer is the tail for receive and the head for transmit. `irq` is the OR over both channels of boundary flag AND interrupt enable, and it falls when the flag is cleared by writing 1.
- R10: When `rx_push` and `tx_pop` arrive in the same cycle, the receive push is serviced. The pop is dropped: no `tx_byte_vld` follows, and the transmit count and head are unchanged.
- R11: The low log2(size) bits of the base register are ignored when RAM addresses are formed. Word 2 reads the absolute head address and word 6 the absolute tail address.
- R12: The CPU memory port writes a byte in the cycle `cpu_mem_we` is high and returns read data one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_reg_we | input | 1 | Register write strobe |
| cpu_reg_addr | input | 4 | Bit 3 picks the channel (0 receive, 1 transmit), bits [2:0] pick the word |
| cpu_reg_wdata | input | 16 | Register write data |
| cpu_reg_rdata | output | 16 | Register read data, combinational from the address |
| cpu_mem_we | input | 1 | CPU RAM write strobe |
| cpu_mem_addr | input | AW | CPU RAM byte address |
| cpu_mem_wdata | input | DW | CPU RAM write data |
| cpu_mem_rdata | output | DW | CPU RAM read data, one cycle after the address |
| rx_push | input | 1 | Peripheral offers a received byte |
| rx_byte | input | DW | Received byte |
| tx_pop | input | 1 | Peripheral requests a byte to transmit |
| tx_byte | output | DW | Byte read for transmission |
| tx_byte_vld | output | 1 | `tx_byte` holds a popped byte |
| irq | output | 1 | Boundary interrupt |

## Verification
The bench sweeps every size code, including the codes that clamp to the RAM size. A design that sized its window from the raw code would report a free count larger than the RAM can hold. It fills the receive window exactly to the brim, then pushes once more. A design with an off-by-one in its free test would either overwrite the oldest byte or raise the boundary flag one byte early or late. It releases and commits counts just above the valid and free counts and then checks that nothing moved, and it retries transfers while an error is pending, which catches a design that lets a stuck channel run on. It also times a push and a pop into the same cycle: a design that arbitrated the other way, or that counted a dropped pop, would shift the transmit head and hand out a byte.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

  // Window size in bytes for a size code, clamped so it fits a RAM of 2^aw bytes.
  function automatic int fifo_bytes(input logic [2:0] code, input int aw);
    int c;
    c = int'(code);
    if (c > aw - 4) c = aw - 4;
    return 1 << (c + 4);
  endfunction

  // Status bit positions
  localparam int ST_OVR = 0;
  localparam int ST_OVW = 1;
  localparam int ST_BND = 2;

endpackage

// File: rtl/rfu_ram.sv
module rfu_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Peripheral port is written last, so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    if (a_we) mem[a_addr] <= a_wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rd <= '0;
      b_rd <= '0;
    end else begin
      a_rd <= mem[a_addr];
      b_rd <= mem[b_addr];
    end
  end

endmodule

// File: rtl/rfu_channel.sv
module rfu_channel #(
  parameter int AW    = 8,
  parameter bit IS_RX = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_code,
  input  logic          cfg_ie,
  input  logic          base_we,
  input  logic [AW-1:0] base_d,
  input  logic          adv_we,
  input  logic [AW:0]   adv_n,
  input  logic          clr_we,
  input  logic [2:0]    clr_bits,
  input  logic          per_req,
  input  logic          per_block,
  output logic          per_acc,
  output logic [AW-1:0] ram_addr,
  output logic [AW-1:0] head_abs,
  output logic [AW-1:0] tail_abs,
  output logic [AW:0]   valid,
  output logic [AW:0]   free,
  output logic [2:0]    stat,
  output logic [2:0]    code,
  output logic          ie,
  output logic [AW-1:0] base,
  output logic          irq
);
  import rfu_pkg::*;

  localparam int CW = AW + 1;

  function automatic logic [AW-1:0] ring_step(input logic [AW-1:0] p,
                                              input logic [CW-1:0] n,
                                              input logic [AW-1:0] m);
    return (p + n[AW-1:0]) & m;
  endfunction

  logic [2:0]    code_q, stat_q;
  logic          ie_q;
  logic [AW-1:0] base_q, head_q, head_d, tail_off, mask, win;
  logic [CW-1:0] count_q, count_d, size, free_w;

  // named internal events, observed by the assertions below
  logic err, gated, cpu_go, per_ok, cpu_ok, ev_ovr, ev_ovw, ev_wrap;

  assign size     = CW'(fifo_bytes(code_q, AW));
  assign mask     = AW'(size - 1'b1);
  assign win      = base_q & ~mask;
  assign free_w   = size - count_q;
  assign tail_off = ring_step(head_q, count_q, mask);
  assign err      = stat_q[ST_OVR] | stat_q[ST_OVW];
  assign gated    = per_req & ~per_block & ~err & ~cfg_we;
  assign cpu_go   = adv_we & ~cfg_we;

  always_comb begin
    per_ok  = 1'b0;
    cpu_ok  = 1'b0;
    ev_ovr  = 1'b0;
    ev_ovw  = 1'b0;
    ev_wrap = 1'b0;
    count_d = count_q;
    head_d  = head_q;
    if (IS_RX) begin
      per_ok  = gated && (free_w != '0);
      ev_ovw  = gated && (free_w == '0);
      ev_wrap = per_ok && (tail_off == mask);
      cpu_ok  = cpu_go && (adv_n <= count_q);
      ev_ovr  = cpu_go && (adv_n > count_q);
      count_d = count_q + CW'(per_ok) - (cpu_ok ? adv_n : '0);
      if (cpu_ok) head_d = ring_step(head_q, adv_n, mask);
    end else begin
      per_ok  = gated && (count_q != '0);
      ev_ovr  = gated && (count_q == '0);
      ev_wrap = per_ok && (head_q == mask);
      cpu_ok  = cpu_go && (adv_n <= free_w);
      ev_ovw  = cpu_go && (adv_n > free_w);
      count_d = count_q + (cpu_ok ? adv_n : '0) - CW'(per_ok);
      if (per_ok) head_d = ring_step(head_q, CW'(1), mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      ie_q    <= 1'b0;
      base_q  <= '0;
      head_q  <= '0;
      count_q <= '0;
      stat_q  <= '0;
    end else begin
      if (cfg_we) begin
        code_q  <= cfg_code;
        ie_q    <= cfg_ie;
        head_q  <= '0;
        count_q <= '0;
      end else begin
        head_q  <= head_d;
        count_q <= count_d;
      end
      if (base_we) base_q <= base_d;
      stat_q <= (clr_we ? (stat_q & ~clr_bits) : stat_q) | {ev_wrap, ev_ovw, ev_ovr};
    end
  end

  assign per_acc  = per_ok;
  assign head_abs = win | head_q;
  assign tail_abs = win | tail_off;
  assign ram_addr = IS_RX ? tail_abs : head_abs;
  assign valid    = count_q;
  assign free     = free_w;
  assign stat     = stat_q;
  assign code     = code_q;
  assign ie       = ie_q;
  assign base     = base_q;
  assign irq      = stat_q[ST_BND] & ie_q;

  // R2: the fill level never exceeds the selected window
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= size);

  // R8: a pending error keeps the peripheral side idle
  p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !per_acc);

  // R8: an error stays until a clear write
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_we) |=> (stat_q[ST_OVR] | stat_q[ST_OVW]));

  // R9: a wrap of the peripheral-side pointer raises the boundary flag
  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> stat_q[ST_BND]);

  // R7 / R6: a refused access with no other activity leaves the count alone
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_ovr || ev_ovw) && !per_ok && !cpu_ok && !cfg_we) |=> $stable(count_q));

endmodule

// File: rtl/ram_fifo_ctl.sv
module ram_fifo_ctl #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_reg_we,
  input  logic [3:0]    cpu_reg_addr,
  input  logic [RW-1:0] cpu_reg_wdata,
  output logic [RW-1:0] cpu_reg_rdata,
  input  logic          cpu_mem_we,
  input  logic [AW-1:0] cpu_mem_addr,
  input  logic [DW-1:0] cpu_mem_wdata,
  output logic [DW-1:0] cpu_mem_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_byte,
  output logic          tx_byte_vld,
  output logic          irq
);
  localparam int NCH = 2;
  localparam int CW  = AW + 1;

  logic [2:0]    idx;
  logic          csel;
  logic          ch_acc  [NCH];
  logic [AW-1:0] ch_addr [NCH];
  logic [AW-1:0] ch_head [NCH];
  logic [AW-1:0] ch_tail [NCH];
  logic [CW-1:0] ch_val  [NCH];
  logic [CW-1:0] ch_free [NCH];
  logic [2:0]    ch_stat [NCH];
  logic [2:0]    ch_code [NCH];
  logic          ch_ie   [NCH];
  logic [AW-1:0] ch_base [NCH];
  logic [NCH-1:0] ch_irq;
  logic          ch_req  [NCH];
  logic          ch_blk  [NCH];

  assign idx  = cpu_reg_addr[2:0];
  assign csel = cpu_reg_addr[3];

  // channel 0 receives, channel 1 transmits; receive wins the RAM port
  assign ch_req[0] = rx_push;
  assign ch_blk[0] = 1'b0;
  assign ch_req[1] = tx_pop;
  assign ch_blk[1] = rx_push;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = cpu_reg_we && (csel == 1'(g));
    rfu_channel #(.AW(AW), .IS_RX(g == 0)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (hit && idx == 3'd0),
      .cfg_code (cpu_reg_wdata[2:0]),
      .cfg_ie   (cpu_reg_wdata[3]),
      .base_we  (hit && idx == 3'd1),
      .base_d   (cpu_reg_wdata[AW-1:0]),
      .adv_we   (hit && idx == 3'd3),
      .adv_n    (cpu_reg_wdata[CW-1:0]),
      .clr_we   (hit && idx == 3'd5),
      .clr_bits (cpu_reg_wdata[2:0]),
      .per_req  (ch_req[g]),
      .per_block(ch_blk[g]),
      .per_acc  (ch_acc[g]),
      .ram_addr (ch_addr[g]),
      .head_abs (ch_head[g]),
      .tail_abs (ch_tail[g]),
      .valid    (ch_val[g]),
      .free     (ch_free[g]),
      .stat     (ch_stat[g]),
      .code     (ch_code[g]),
      .ie       (ch_ie[g]),
      .base     (ch_base[g]),
      .irq      (ch_irq[g])
    );
  end

  logic          rx_acc, tx_acc;
  logic [AW-1:0] per_addr;

  assign rx_acc   = ch_acc[0];
  assign tx_acc   = ch_acc[1];
  assign per_addr = rx_acc ? ch_addr[0] : ch_addr[1];

  rfu_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .a_we  (rx_acc),
    .a_addr(per_addr),
    .a_wd  (rx_byte),
    .a_rd  (tx_byte),
    .b_we  (cpu_mem_we),
    .b_addr(cpu_mem_addr),
    .b_wd  (cpu_mem_wdata),
    .b_rd  (cpu_mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tx_byte_vld <= 1'b0;
    else        tx_byte_vld <= tx_acc;
  end

  assign irq = |ch_irq;

  always_comb begin
    case (idx)
      3'd0:    cpu_reg_rdata = RW'({ch_ie[csel], ch_code[csel]});
      3'd1:    cpu_reg_rdata = RW'(ch_base[csel]);
      3'd2:    cpu_reg_rdata = RW'(ch_head[csel]);
      3'd3:    cpu_reg_rdata = RW'(ch_val[csel]);
      3'd4:    cpu_reg_rdata = RW'(ch_free[csel]);
      3'd5:    cpu_reg_rdata = RW'(ch_stat[csel]);
      3'd6:    cpu_reg_rdata = RW'(ch_tail[csel]);
      default: cpu_reg_rdata = '0;
    endcase
  end

  // R10: a push and a pop in one cycle never both reach the RAM port
  p_rx_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_acc |-> !tx_acc);

  // R4: a popped byte is flagged exactly one cycle after acceptance
  p_tx_vld_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_acc |=> tx_byte_vld);

  // R9: the interrupt only follows an enabled channel's boundary flag
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ch_stat[0][2] && ch_ie[0]) || (ch_stat[1][2] && ch_ie[1])));

endmodule

// File: tb/ram_fifo_ctl_test.sv
module ram_fifo_ctl_test;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_reg_we = 1'b0;
  logic [3:0]    cpu_reg_addr = '0;
  logic [15:0]   cpu_reg_wdata = '0;
  logic [15:0]   cpu_reg_rdata;
  logic          cpu_mem_we = 1'b0;
  logic [AW-1:0] cpu_mem_addr = '0;
  logic [DW-1:0] cpu_mem_wdata = '0;
  logic [DW-1:0] cpu_mem_rdata;
  logic          rx_push = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          tx_pop = 1'b0;
  logic [DW-1:0] tx_byte;
  logic          tx_byte_vld;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  ram_fifo_ctl #(.AW(AW), .DW(DW), .RW(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_reg_we(cpu_reg_we), .cpu_reg_addr(cpu_reg_addr),
    .cpu_reg_wdata(cpu_reg_wdata), .cpu_reg_rdata(cpu_reg_rdata),
    .cpu_mem_we(cpu_mem_we), .cpu_mem_addr(cpu_mem_addr),
    .cpu_mem_wdata(cpu_mem_wdata), .cpu_mem_rdata(cpu_mem_rdata),
    .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_byte_vld(tx_byte_vld),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    cpu_reg_we = 1'b1; cpu_reg_addr = a; cpu_reg_wdata = 16'(d);
    @(negedge clk);
    cpu_reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    cpu_reg_addr = a;
    #1 v = int'(cpu_reg_rdata);
  endtask

  task automatic mwr(input int a, input int d);
    @(negedge clk);
    cpu_mem_we = 1'b1; cpu_mem_addr = AW'(a); cpu_mem_wdata = DW'(d);
    @(negedge clk);
    cpu_mem_we = 1'b0;
  endtask

  task automatic mrd(input int a, output int v);
    @(negedge clk);
    cpu_mem_addr = AW'(a);
    @(negedge clk);
    #1 v = int'(cpu_mem_rdata);
  endtask

  task automatic push(input int d);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = DW'(d);
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop(output int vld, output int b);
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
    #1 vld = int'(tx_byte_vld); b = int'(tx_byte);
  endtask

  function automatic int exp_size(input int c);
    int e;
    e = (c < AW - 4) ? c : AW - 4;
    return 16 << e;
  endfunction

  // register word addresses: receive 0..6, transmit 8..14
  localparam logic [3:0] RX_CFG = 4'd0, RX_BASE = 4'd1, RX_HEAD = 4'd2, RX_CNT = 4'd3,
                         RX_FREE = 4'd4, RX_STAT = 4'd5, RX_TAIL = 4'd6;
  localparam logic [3:0] TX_CFG = 4'd8, TX_BASE = 4'd9, TX_HEAD = 4'd10, TX_CNT = 4'd11,
                         TX_FREE = 4'd12, TX_STAT = 4'd13;

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, vld, b, th;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(RX_CNT, v);  chk("R1 rx valid", v, 0);
    rd(RX_FREE, v); chk("R1 rx free", v, 16);
    rd(TX_FREE, v); chk("R1 tx free", v, 16);
    rd(RX_STAT, v); chk("R1 rx stat", v, 0);
    rd(TX_CFG, v);  chk("R1 tx cfg", v, 0);
    chk("R1 irq", int'(irq), 0);

    // R2 size code sweep, including clamped codes
    for (int c = 0; c < 8; c++) begin
      wr(RX_CFG, c);
      rd(RX_FREE, v); chk("R2 free after size code", v, exp_size(c));
      rd(RX_CNT, v);  chk("R2 valid after size code", v, 0);
    end
    wr(RX_CFG, 0);

    // R3 / R11 fill the 16-byte receive window, misaligned base
    wr(RX_BASE, 8'h23);
    for (int i = 0; i < 16; i++) begin
      push((i * 7 + 1) & 255);
      rd(RX_CNT, v);  chk("R3 valid after push", v, i + 1);
      rd(RX_TAIL, v); chk("R11 tail address", v, 8'h20 + ((i + 1) % 16));
      rd(RX_STAT, v); chk("R9 rx boundary on wrap only", v, (i == 15) ? 4 : 0);
    end
    chk("R9 irq masked when enable off", int'(irq), 0);
    for (int i = 0; i < 16; i++) begin
      mrd(8'h20 + i, v); chk("R3 R12 stored byte", v, (i * 7 + 1) & 255);
    end
    wr(RX_STAT, 7);
    rd(RX_STAT, v); chk("R9 clear by writing one", v, 0);

    // R6 push into a full window
    push(8'hEE);
    rd(RX_STAT, v); chk("R6 over-write flag", v, 2);
    rd(RX_CNT, v);  chk("R6 count unchanged", v, 16);
    mrd(8'h20, v);  chk("R6 oldest byte kept", v, 1);

    // R5 release while the error is still pending
    wr(RX_CNT, 5);
    rd(RX_CNT, v);  chk("R5 valid after release", v, 11);
    rd(RX_HEAD, v); chk("R5 head after release", v, 8'h25);

    // R8 push ignored while flagged
    push(8'hAB);
    rd(RX_CNT, v);  chk("R8 push ignored during error", v, 11);
    wr(RX_STAT, 2);
    rd(RX_STAT, v); chk("R8 flag cleared", v, 0);
    push(8'hAB);
    rd(RX_CNT, v);  chk("R3 push resumes", v, 12);
    mrd(8'h20, v);  chk("R3 wrapped write address", v, 8'hAB);

    // R7 release beyond the valid count
    wr(RX_CNT, 20);
    rd(RX_STAT, v); chk("R7 over-read on release", v, 1);
    rd(RX_CNT, v);  chk("R7 count unchanged", v, 12);
    rd(RX_HEAD, v); chk("R7 head unchanged", v, 8'h25);
    wr(RX_STAT, 1);

    // R4 transmit channel: 32-byte window with interrupt enable
    wr(TX_CFG, 1 | 8);
    wr(TX_BASE, 8'h40);
    for (int i = 0; i < 32; i++) mwr(8'h40 + i, 8'h80 + i);
    wr(TX_CNT, 10);
    rd(TX_CNT, v);  chk("R4 valid after commit", v, 10);
    rd(TX_FREE, v); chk("R4 free after commit", v, 22);
    for (int i = 0; i < 10; i++) begin
      pop(vld, b);
      chk("R4 pop valid", vld, 1);
      chk("R4 pop byte", b, 8'h80 + i);
    end
    rd(TX_HEAD, v); chk("R4 head after pops", v, 8'h4A);

    // R7 pop from empty, R8 pop ignored while flagged
    pop(vld, b);
    chk("R7 no byte from empty", vld, 0);
    rd(TX_STAT, v); chk("R7 tx over-read flag", v, 1);
    wr(TX_CNT, 3);
    pop(vld, b);
    chk("R8 pop ignored during error", vld, 0);
    rd(TX_CNT, v);  chk("R8 tx count kept", v, 3);
    wr(TX_STAT, 1);
    for (int i = 0; i < 3; i++) begin
      pop(vld, b);
      chk("R4 pop after clear", b, 8'h80 + 10 + i);
    end

    // R6 commit beyond free space
    wr(TX_CNT, 33);
    rd(TX_STAT, v); chk("R6 tx over-write flag", v, 2);
    rd(TX_CNT, v);  chk("R6 tx count unchanged", v, 0);
    wr(TX_STAT, 2);

    // R9 transmit head wrap raises the interrupt
    th = 13;
    wr(TX_CNT, 19);
    for (int k = 0; k < 19; k++) begin
      pop(vld, b);
      chk("R9 pop across wrap", b, 8'h80 + ((th + k) % 32));
      if (k == 17) chk("R9 irq low before wrap", int'(irq), 0);
    end
    rd(TX_STAT, v); chk("R9 tx boundary flag", v, 4);
    chk("R9 irq raised", int'(irq), 1);
    wr(TX_STAT, 4);
    chk("R9 irq cleared", int'(irq), 0);

    // R10 push and pop in the same cycle
    wr(TX_CNT, 2);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = 8'h5A; tx_pop = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; tx_pop = 1'b0;
    #1 chk("R10 pop dropped on conflict", int'(tx_byte_vld), 0);
    rd(TX_CNT, v);  chk("R10 tx count unchanged", v, 2);
    rd(TX_HEAD, v); chk("R10 tx head unchanged", v, 8'h40);
    rd(RX_CNT, v);  chk("R10 push serviced", v, 13);
    pop(vld, b);
    chk("R10 later pop byte", b, 8'h80);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule